// File: doc/BRIEF.md
# Receive Descriptor DMA Sequencer

This block is the control state machine of a receive DMA engine that works through a ring of descriptors. A start command makes it ask a descriptor fetcher for the next descriptor. When the descriptor belongs to the DMA, the sequencer waits for the receive buffer to report a pending frame. It then asks a data mover to copy that frame to host memory and asks for the descriptor to be closed. Before it prefetches the next descriptor, it waits until the receive buffer reports that the end of the frame has gone out.

A descriptor that the host still owns means the DMA has nowhere to put data. In that case the sequencer suspends. If a frame is already waiting when this happens, it first tells the receive buffer to flush that frame. A poll command wakes a suspended sequencer, and a stop command halts it from any state. The 3-bit state code is exported so that a status register can show it. Three one-cycle event pulses feed an interrupt controller: receive done, buffer unavailable and process stopped. Bus mastering and frame storage are outside this block.

Top module: `rx_desc_seq`

## Requirements
- R1: After reset the state code is 000 (stopped), all four request outputs are low and no event pulse is raised.
- R2: In state 000 a start command moves the sequencer to state 001 (descriptor fetch) in the next cycle. A start command in any other state has no effect.
- R3: The normal path runs from 001 to 011 (waiting for frame) when the fetch completes with a DMA-owned descriptor. It goes from 011 to 111 (moving frame) while a frame is available, from 111 to 101 (closing descriptor) on move done, and from 101 to 010 (end-of-frame check) on close done. The close-done transition raises the receive-done pulse for the first cycle of state 010.
- R4: A fetch that completes with a host-owned descriptor raises the buffer-unavailable pulse for one cycle. The sequencer then goes to state 110 (flushing) when a frame is available at that moment, and to state 100 (suspended) otherwise.
- R5: In state 110, flush done moves the sequencer to state 100.
- R6: In state 100 a poll command moves the sequencer to state 001. Without a poll it stays in 100, and a poll in any other state has no effect.
- R7: A stop command in any state other than 000 moves the sequencer to 000 in the next cycle, ahead of any other input. The process-stopped pulse is raised once, for the first cycle of state 000. A stop command given while already in 000 raises no pulse.
- R8: Each request output is high exactly while the sequencer is in its state: fetch request in 001, move request in 111, close request in 101, flush request in 110.
- R9: In state 010 the sequencer stays in 010 while the end-of-frame input is low, and it moves to 001 when the input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-receive command |
| stop_i | input | 1 | Stop-receive command, highest priority |
| poll_i | input | 1 | Poll command; resumes from suspend |
| dfetch_req_o | output | 1 | Descriptor fetch request |
| dfetch_done_i | input | 1 | Descriptor fetch complete |
| dfetch_own_i | input | 1 | Fetched descriptor owned by DMA (1) or host (0) |
| frame_avail_i | input | 1 | Receive buffer holds a pending frame |
| eof_i | input | 1 | Receive buffer has reached end of frame |
| flush_req_o | output | 1 | Flush request to receive buffer |
| flush_done_i | input | 1 | Flush complete |
| move_req_o | output | 1 | Frame copy request to data mover |
| move_done_i | input | 1 | Frame copy complete |
| close_req_o | output | 1 | Descriptor close request |
| close_done_i | input | 1 | Descriptor close complete |
| state_o | output | 3 | Current state code |
| rx_int_o | output | 1 | Receive-done event pulse |
| rx_unavail_o | output | 1 | Buffer-unavailable event pulse |
| rx_stopped_o | output | 1 | Process-stopped event pulse |

## Verification
Several rules are checked by assertions on every cycle: that stop takes priority, that the suspended and end-of-frame-check states hold, that a start from the stopped state is taken, that an open request is held, and that each event pulse lines up with the state transition that caused it. The bench scenarios are the only way to show that whole paths through the state codes are taken. These include the normal receive loop, the choice between flushing and suspending at fetch time, and the resume on poll. The scenarios also show that a start or poll outside its state leaves the state code unchanged, and that a stop given while already stopped raises no pulse.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;

   localparam int RX_STATE_W = 3;

   // State codes are visible at the top-level port; values are fixed.
   typedef enum logic [RX_STATE_W-1:0] {
      ST_STOP   = 3'b000,
      ST_FETCH  = 3'b001,
      ST_EOFCHK = 3'b010,
      ST_WAIT   = 3'b011,
      ST_SUSP   = 3'b100,
      ST_CLOSE  = 3'b101,
      ST_FLUSH  = 3'b110,
      ST_MOVE   = 3'b111
   } rx_state_e;

   typedef struct packed {
      logic intr;
      logic unavail;
      logic stopped;
   } rx_evt_t;

   localparam int RX_EVT_W = $bits(rx_evt_t);

endpackage

// File: rtl/rx_seq_fsm.sv
module rx_seq_fsm
   import rx_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      stop_i,
   input  logic      poll_i,
   input  logic      dfetch_done_i,
   input  logic      dfetch_own_i,
   input  logic      frame_avail_i,
   input  logic      eof_i,
   input  logic      flush_done_i,
   input  logic      move_done_i,
   input  logic      close_done_i,
   output rx_state_e state_q,
   output rx_evt_t   evt_d
);

   rx_state_e state_d;

   always_comb begin
      state_d = state_q;
      evt_d   = '0;
      if (stop_i) begin
         state_d       = ST_STOP;
         evt_d.stopped = (state_q != ST_STOP);
      end else begin
         unique case (state_q)
            ST_STOP:   if (start_i) state_d = ST_FETCH;
            ST_FETCH:  if (dfetch_done_i) begin
                          if (dfetch_own_i) begin
                             state_d = ST_WAIT;
                          end else begin
                             evt_d.unavail = 1'b1;
                             state_d = frame_avail_i ? ST_FLUSH : ST_SUSP;
                          end
                       end
            ST_WAIT:   if (frame_avail_i) state_d = ST_MOVE;
            ST_MOVE:   if (move_done_i) state_d = ST_CLOSE;
            ST_CLOSE:  if (close_done_i) begin
                          state_d    = ST_EOFCHK;
                          evt_d.intr = 1'b1;
                       end
            ST_EOFCHK: if (eof_i) state_d = ST_FETCH;
            ST_FLUSH:  if (flush_done_i) state_d = ST_SUSP;
            ST_SUSP:   if (poll_i) state_d = ST_FETCH;
            default:   state_d = ST_STOP;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_STOP;
      else        state_q <= state_d;
   end

   // R7: stop wins over every other input
   p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> state_q == ST_STOP);

   // R2: start from stopped is taken
   p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STOP && start_i && !stop_i) |=> state_q == ST_FETCH);

   // R6: suspended state holds until poll
   p_susp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SUSP && !poll_i && !stop_i) |=> state_q == ST_SUSP);

   // R9: end-of-frame check holds until end of frame
   p_eof_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EOFCHK && !eof_i && !stop_i) |=> state_q == ST_EOFCHK);

endmodule

// File: rtl/rx_seq_req.sv
module rx_seq_req
   import rx_seq_pkg::*;
#(
   parameter int NUM_REQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  rx_state_e          state_i,
   input  logic               stop_i,
   input  logic [NUM_REQ-1:0] done_i,
   output logic [NUM_REQ-1:0] req_o
);

   // Request order: fetch, close, flush, move
   localparam rx_state_e REQ_ST [4] = '{ST_FETCH, ST_CLOSE, ST_FLUSH, ST_MOVE};

   if (NUM_REQ != 4) begin : g_bad_num
      $error("rx_seq_req: NUM_REQ must be 4");
   end

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
      assign req_o[g] = (state_i == REQ_ST[g]);

      // R8: an open request stays open until its done or a stop
      p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (req_o[g] && !done_i[g] && !stop_i) |=> req_o[g]);
   end

endmodule

// File: rtl/rx_seq_evt.sv
module rx_seq_evt
   import rx_seq_pkg::*;
#(
   parameter bit REG_EVENTS = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  rx_state_e state_i,
   input  rx_evt_t   evt_d,
   output rx_evt_t   evt_o
);

   if (REG_EVENTS) begin : g_reg
      rx_evt_t evt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) evt_q <= '0;
         else        evt_q <= evt_d;
      end
      assign evt_o = evt_q;

      // R3: receive-done pulse marks first cycle of the end-of-frame check
      p_int_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
         evt_o.intr |-> (state_i == ST_EOFCHK && $past(state_i) == ST_CLOSE));

      // R4: unavailable pulse follows a fetch
      p_unavail_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
         evt_o.unavail |-> ((state_i == ST_FLUSH || state_i == ST_SUSP)
                            && $past(state_i) == ST_FETCH));

      // R7: stopped pulse only on entry into stopped
      p_stopped_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
         evt_o.stopped |-> (state_i == ST_STOP && $past(state_i) != ST_STOP));
   end else begin : g_comb
      assign evt_o = evt_d;
   end

endmodule

// File: rtl/rx_desc_seq.sv
module rx_desc_seq
   import rx_seq_pkg::*;
#(
   parameter int STATE_W    = 3,
   parameter bit REG_EVENTS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               poll_i,
   output logic               dfetch_req_o,
   input  logic               dfetch_done_i,
   input  logic               dfetch_own_i,
   input  logic               frame_avail_i,
   input  logic               eof_i,
   output logic               flush_req_o,
   input  logic               flush_done_i,
   output logic               move_req_o,
   input  logic               move_done_i,
   output logic               close_req_o,
   input  logic               close_done_i,
   output logic [STATE_W-1:0] state_o,
   output logic               rx_int_o,
   output logic               rx_unavail_o,
   output logic               rx_stopped_o
);

   localparam int NUM_REQ = 4;

   if (STATE_W != RX_STATE_W) begin : g_bad_w
      $error("rx_desc_seq: STATE_W must match the state code width");
   end

   rx_state_e          state_q;
   rx_evt_t            evt_d;
   rx_evt_t            evt_q;
   logic [NUM_REQ-1:0] req;

   rx_seq_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .stop_i        (stop_i),
      .poll_i        (poll_i),
      .dfetch_done_i (dfetch_done_i),
      .dfetch_own_i  (dfetch_own_i),
      .frame_avail_i (frame_avail_i),
      .eof_i         (eof_i),
      .flush_done_i  (flush_done_i),
      .move_done_i   (move_done_i),
      .close_done_i  (close_done_i),
      .state_q       (state_q),
      .evt_d         (evt_d)
   );

   rx_seq_req #(.NUM_REQ(NUM_REQ)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (state_q),
      .stop_i  (stop_i),
      .done_i  ({move_done_i, flush_done_i, close_done_i, dfetch_done_i}),
      .req_o   (req)
   );

   rx_seq_evt #(.REG_EVENTS(REG_EVENTS)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (state_q),
      .evt_d   (evt_d),
      .evt_o   (evt_q)
   );

   assign dfetch_req_o = req[0];
   assign close_req_o  = req[1];
   assign flush_req_o  = req[2];
   assign move_req_o   = req[3];
   assign state_o      = state_q;
   assign rx_int_o     = evt_q.intr;
   assign rx_unavail_o = evt_q.unavail;
   assign rx_stopped_o = evt_q.stopped;

endmodule

// File: tb/rx_desc_seq_tb.sv
`timescale 1ns/1ps
module rx_desc_seq_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 0, stop_i = 0, poll_i = 0;
   logic dfetch_done_i = 0, dfetch_own_i = 0, frame_avail_i = 0, eof_i = 0;
   logic flush_done_i = 0, move_done_i = 0, close_done_i = 0;
   logic dfetch_req_o, flush_req_o, move_req_o, close_req_o;
   logic [2:0] state_o;
   logic rx_int_o, rx_unavail_o, rx_stopped_o;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   rx_desc_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .poll_i(poll_i),
      .dfetch_req_o(dfetch_req_o), .dfetch_done_i(dfetch_done_i), .dfetch_own_i(dfetch_own_i),
      .frame_avail_i(frame_avail_i), .eof_i(eof_i), .flush_req_o(flush_req_o),
      .flush_done_i(flush_done_i), .move_req_o(move_req_o), .move_done_i(move_done_i),
      .close_req_o(close_req_o), .close_done_i(close_done_i), .state_o(state_o),
      .rx_int_o(rx_int_o), .rx_unavail_o(rx_unavail_o), .rx_stopped_o(rx_stopped_o)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic int reqs();
      return {dfetch_req_o, move_req_o, close_req_o, flush_req_o};
   endfunction

   function automatic int evts();
      return {rx_int_o, rx_unavail_o, rx_stopped_o};
   endfunction

   task automatic do_start();
      start_i = 1; tick(); start_i = 0;
   endtask

   task automatic t_reset();
      rst_n = 0; tick(); tick();
      chk("R1 state", state_o, 0);
      chk("R1 reqs", reqs(), 0);
      chk("R1 events", evts(), 0);
      rst_n = 1; tick();
      chk("R1 idle after reset", state_o, 0);
   endtask

   task automatic t_start();
      do_start();
      chk("R2 start -> 001", state_o, 1);
      chk("R8 fetch req", reqs(), 4'b1000);
      do_start();
      chk("R2 start ignored in 001", state_o, 1);
   endtask

   task automatic t_normal();
      dfetch_own_i = 1; dfetch_done_i = 1; tick(); dfetch_done_i = 0;
      chk("R3 own -> 011", state_o, 3);
      chk("R8 no req in 011", reqs(), 0);
      tick();
      chk("R3 wait holds", state_o, 3);
      frame_avail_i = 1; tick();
      chk("R3 frame -> 111", state_o, 7);
      chk("R8 move req", reqs(), 4'b0100);
      move_done_i = 1; tick(); move_done_i = 0;
      chk("R3 move done -> 101", state_o, 5);
      chk("R8 close req", reqs(), 4'b0010);
      close_done_i = 1; tick(); close_done_i = 0;
      chk("R3 close -> 010", state_o, 2);
      chk("R3 rx_int pulse", rx_int_o, 1);
      frame_avail_i = 0; tick();
      chk("R3 rx_int one cycle", rx_int_o, 0);
      chk("R9 hold without eof", state_o, 2);
      tick();
      chk("R9 still hold", state_o, 2);
      eof_i = 1; tick(); eof_i = 0;
      chk("R9 eof -> 001", state_o, 1);
   endtask

   task automatic t_unavail_empty();
      dfetch_own_i = 0; frame_avail_i = 0; dfetch_done_i = 1; tick(); dfetch_done_i = 0;
      chk("R4 empty -> 100", state_o, 4);
      chk("R4 unavail pulse", rx_unavail_o, 1);
      tick();
      chk("R4 unavail one cycle", rx_unavail_o, 0);
      chk("R6 suspend holds", state_o, 4);
      poll_i = 1; tick(); poll_i = 0;
      chk("R6 poll -> 001", state_o, 1);
   endtask

   task automatic t_unavail_flush();
      dfetch_own_i = 0; frame_avail_i = 1; dfetch_done_i = 1; tick(); dfetch_done_i = 0;
      chk("R4 pending -> 110", state_o, 6);
      chk("R4 unavail pulse with flush", rx_unavail_o, 1);
      chk("R8 flush req", reqs(), 4'b0001);
      tick();
      chk("R5 flush holds", state_o, 6);
      flush_done_i = 1; tick(); flush_done_i = 0;
      frame_avail_i = 0;
      chk("R5 flush done -> 100", state_o, 4);
      poll_i = 1; tick(); poll_i = 0;
      chk("R6 poll after flush", state_o, 1);
   endtask

   task automatic t_poll_ignored();
      dfetch_own_i = 1; dfetch_done_i = 1; tick(); dfetch_done_i = 0;
      poll_i = 1; tick(); poll_i = 0;
      chk("R6 poll ignored in 011", state_o, 3);
   endtask

   task automatic t_stop();
      stop_i = 1; tick(); stop_i = 0;
      chk("R7 stop from 011", state_o, 0);
      chk("R7 stopped pulse", rx_stopped_o, 1);
      tick();
      chk("R7 stopped one cycle", rx_stopped_o, 0);
      stop_i = 1; tick(); stop_i = 0;
      chk("R7 no pulse when stopped", rx_stopped_o, 0);
      chk("R7 stays stopped", state_o, 0);
      poll_i = 1; tick(); poll_i = 0;
      chk("R6 poll ignored in 000", state_o, 0);
      do_start();
      dfetch_own_i = 1; dfetch_done_i = 1; tick(); dfetch_done_i = 0;
      frame_avail_i = 1; tick();
      chk("R3 to move again", state_o, 7);
      stop_i = 1; move_done_i = 1; tick(); stop_i = 0; move_done_i = 0;
      frame_avail_i = 0;
      chk("R7 stop beats move done", state_o, 0);
      chk("R7 pulse from 111", rx_stopped_o, 1);
      chk("R7 no reqs stopped", reqs(), 0);
   endtask

   initial begin
      tick();
      t_reset();
      t_start();
      t_normal();
      t_unavail_empty();
      t_unavail_flush();
      t_poll_ignored();
      t_stop();
      tick();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule